// File: doc/BRIEF.md
# Condition Code Flag Unit

This block holds the four status flags that sit beside an integer ALU: negative, overflow, positive and zero. It also decides whether a conditional branch is taken. Each cycle the ALU presents its 32-bit result and its two's-complement overflow indication. The flags are rewritten only when the current instruction asserts its set-flags bit. Instructions that leave that bit low pass through without touching the flags. A compiler can therefore place the test (for example a subtract) several instructions ahead of the branch that consumes it.

The branch evaluator reads the stored flags and a 3-bit condition select. It produces a combinational taken decision. A compare-and-branch is built from a flag-setting subtract followed, at any later point, by a branch on the negative flag.

Top module: `ccu_top`

## Requirements
- R1: While reset is active, and after it is released, all four flags read 0 until the first update.
- R2: An update sets the negative flag to bit 31 of the ALU result.
- R3: An update sets the zero flag exactly when all 32 result bits are 0.
- R4: An update sets the positive flag exactly when the result is nonzero and bit 31 is clear. After any update exactly one of negative, zero and positive is 1.
- R5: An update copies the ALU overflow input into the overflow flag, independent of the result value.
- R6: In a cycle where set_flags is 0, the ALU result and overflow inputs have no effect, and all four flags keep their values.
- R7: An update becomes visible on the flag outputs after the rising clock edge that samples set_flags high, and not before.
- R8: The branch decision uses the stored flags and the select codes 0 always, 1 negative set, 2 zero set, 3 positive set, 4 overflow set, 5 negative clear, 6 zero clear, 7 positive clear.
- R9: A flag-setting subtract result followed by non-setting instructions still steers a later branch on the negative flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alu_result | input | 32 | Result of the current ALU operation |
| alu_ovf | input | 1 | Two's-complement overflow of the current operation |
| set_flags | input | 1 | Current instruction requests a flag update |
| cond_sel | input | 3 | Branch condition select |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_p | output | 1 | Positive flag |
| flag_z | output | 1 | Zero flag |
| take_branch | output | 1 | Selected condition holds on the stored flags |

## Verification
The checker watches every cycle for the following. Negative, zero and overflow must follow the previous cycle's inputs whenever an update was requested. The flags must stay stable when no update was requested. At most one of negative, zero and positive may be set. The always condition and the negative and zero conditions must agree with the flags.

Other behaviours only show up in the directed scenarios. These are the ordering of an update relative to the clock edge, the full sweep of all eight conditions over each flag pattern, the boundary results 0, 0x7FFFFFFF and 0x80000000, and a test kept alive across non-setting instructions.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

  typedef enum logic [2:0] {
    COND_ALWAYS = 3'd0,
    COND_NEG    = 3'd1,
    COND_ZERO   = 3'd2,
    COND_POS    = 3'd3,
    COND_OVF    = 3'd4,
    COND_NNEG   = 3'd5,
    COND_NZERO  = 3'd6,
    COND_NPOS   = 3'd7
  } cond_sel_e;

  typedef struct packed {
    logic neg;
    logic ovf;
    logic pos;
    logic zero;
  } ccu_flags_t;

endpackage

// File: rtl/ccu_rst_sync.sv
module ccu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ccu_flag_gen.sv
module ccu_flag_gen
  import ccu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] result,
  input  logic              ovf_in,
  output ccu_flags_t        flags_nxt
);
  localparam int SIGN_BIT = DATA_W - 1;

  logic is_zero;

  always_comb begin
    is_zero         = (result == '0);
    flags_nxt.neg   = result[SIGN_BIT];
    flags_nxt.zero  = is_zero;
    flags_nxt.pos   = ~result[SIGN_BIT] & ~is_zero;
    flags_nxt.ovf   = ovf_in;
  end
endmodule

// File: rtl/ccu_flag_reg.sv
module ccu_flag_reg
  import ccu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  ccu_flags_t d,
  output ccu_flags_t q
);
  ccu_flags_t q_nxt;

  always_comb begin
    q_nxt = q;
    if (load) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/ccu_branch_eval.sv
module ccu_branch_eval
  import ccu_pkg::*;
(
  input  ccu_flags_t flags,
  input  cond_sel_e  cond,
  output logic       take
);
  always_comb begin
    unique case (cond)
      COND_ALWAYS: take = 1'b1;
      COND_NEG:    take = flags.neg;
      COND_ZERO:   take = flags.zero;
      COND_POS:    take = flags.pos;
      COND_OVF:    take = flags.ovf;
      COND_NNEG:   take = ~flags.neg;
      COND_NZERO:  take = ~flags.zero;
      COND_NPOS:   take = ~flags.pos;
      default:     take = 1'b0;
    endcase
  end
endmodule

// File: rtl/ccu_top.sv
module ccu_top
  import ccu_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_ovf,
  input  logic              set_flags,
  input  logic [2:0]        cond_sel,
  output logic              flag_n,
  output logic              flag_v,
  output logic              flag_p,
  output logic              flag_z,
  output logic              take_branch
);
  logic       rst_int_n;
  ccu_flags_t flags_nxt;
  ccu_flags_t flags_q;

  ccu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  ccu_flag_gen #(.DATA_W(DATA_W)) u_gen (
    .result    (alu_result),
    .ovf_in    (alu_ovf),
    .flags_nxt (flags_nxt)
  );

  ccu_flag_reg u_reg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (set_flags),
    .d     (flags_nxt),
    .q     (flags_q)
  );

  ccu_branch_eval u_br (
    .flags (flags_q),
    .cond  (cond_sel_e'(cond_sel)),
    .take  (take_branch)
  );

  assign flag_n = flags_q.neg;
  assign flag_v = flags_q.ovf;
  assign flag_p = flags_q.pos;
  assign flag_z = flags_q.zero;
endmodule

// File: rtl/ccu_checker.sv
module ccu_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic [DATA_W-1:0] alu_result,
  input logic              alu_ovf,
  input logic              set_flags,
  input logic [2:0]        cond_sel,
  input logic              flag_n,
  input logic              flag_v,
  input logic              flag_p,
  input logic              flag_z,
  input logic              take_branch
);
  // R1: flags clear while reset is held
  always @(posedge clk) begin
    if (!rst_int_n)
      a_r1_reset_clear: assert ({flag_n, flag_v, flag_p, flag_z} == 4'b0);
  end

  a_r2_neg_bit: assert property (@(posedge clk) disable iff (!rst_int_n)
    set_flags |=> flag_n == $past(alu_result[DATA_W-1]));

  a_r3_zero_detect: assert property (@(posedge clk) disable iff (!rst_int_n)
    set_flags |=> flag_z == ($past(alu_result) == '0));

  a_r4_one_sign_flag: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({flag_n, flag_p, flag_z}));

  a_r5_ovf_copy: assert property (@(posedge clk) disable iff (!rst_int_n)
    set_flags |=> flag_v == $past(alu_ovf));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    !set_flags |=> $stable({flag_n, flag_v, flag_p, flag_z}));

  a_r8_always: assert property (@(posedge clk) disable iff (!rst_int_n)
    cond_sel == 3'd0 |-> take_branch);

  a_r8_neg_cond: assert property (@(posedge clk) disable iff (!rst_int_n)
    cond_sel == 3'd1 |-> take_branch == flag_n);

  a_r8_nzero_cond: assert property (@(posedge clk) disable iff (!rst_int_n)
    cond_sel == 3'd6 |-> take_branch == !flag_z);
endmodule

bind ccu_top ccu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_int_n   (rst_int_n),
  .alu_result  (alu_result),
  .alu_ovf     (alu_ovf),
  .set_flags   (set_flags),
  .cond_sel    (cond_sel),
  .flag_n      (flag_n),
  .flag_v      (flag_v),
  .flag_p      (flag_p),
  .flag_z      (flag_z),
  .take_branch (take_branch)
);

// File: tb/tb_ccu_top.sv
`timescale 1ns/100ps
module tb_ccu_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] alu_result;
  logic        alu_ovf;
  logic        set_flags;
  logic [2:0]  cond_sel;
  logic        flag_n, flag_v, flag_p, flag_z, take_branch;

  int checks = 0;
  int fails  = 0;
  logic m_n = 0, m_v = 0, m_p = 0, m_z = 0;

  always #2 clk = ~clk;

  ccu_top dut (
    .clk(clk), .rst_n(rst_n), .alu_result(alu_result), .alu_ovf(alu_ovf),
    .set_flags(set_flags), .cond_sel(cond_sel), .flag_n(flag_n),
    .flag_v(flag_v), .flag_p(flag_p), .flag_z(flag_z),
    .take_branch(take_branch)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic cond_ref(input int c);
    case (c)
      0: return 1'b1;
      1: return m_n;
      2: return m_z;
      3: return m_p;
      4: return m_v;
      5: return !m_n;
      6: return !m_z;
      default: return !m_p;
    endcase
  endfunction

  task automatic check_flags(input string req);
    chk({flag_n, flag_v, flag_p, flag_z} == {m_n, m_v, m_p, m_z}, req,
        {28'd0, flag_n, flag_v, flag_p, flag_z}, {28'd0, m_n, m_v, m_p, m_z});
  endtask

  // one instruction: drive at negedge, sample after the edge
  task automatic issue(input logic [31:0] res, input logic ovf, input logic set);
    @(negedge clk);
    alu_result = res; alu_ovf = ovf; set_flags = set;
    @(posedge clk); #1;
    set_flags = 1'b0;
    if (set) begin
      m_n = res[31]; m_z = (res == 0); m_p = !res[31] && (res != 0); m_v = ovf;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; alu_result = 32'hFFFF_FFFF; alu_ovf = 1'b1;
    set_flags = 1'b1; cond_sel = 3'd0;
    repeat (3) @(posedge clk);
    #1 check_flags("R1 in reset");
    @(negedge clk); rst_n = 1'b1; set_flags = 1'b0;
    repeat (4) @(posedge clk);
    #1 check_flags("R1 after release");
  endtask

  task automatic t_negative;
    issue(32'h8000_0000, 1'b0, 1'b1); check_flags("R2 R4 min negative");
    issue(32'hFFFF_FFFC, 1'b0, 1'b1); check_flags("R2 R4 minus four");
  endtask

  task automatic t_zero;
    issue(32'h0000_0000, 1'b0, 1'b1); check_flags("R3 zero result");
    issue(32'h0000_0001, 1'b0, 1'b1); check_flags("R3 R4 one");
  endtask

  task automatic t_positive;
    issue(32'h7FFF_FFFF, 1'b0, 1'b1); check_flags("R4 max positive");
    chk($countones({flag_n, flag_p, flag_z}) == 1, "R4 exactly one",
        {29'd0, flag_n, flag_p, flag_z}, 32'd1);
  endtask

  task automatic t_overflow;
    issue(32'h8000_0000, 1'b1, 1'b1); check_flags("R5 ovf with negative");
    issue(32'h0000_0000, 1'b1, 1'b1); check_flags("R5 ovf with zero");
    issue(32'h0000_0005, 1'b0, 1'b1); check_flags("R5 ovf cleared");
  endtask

  task automatic t_hold;
    issue(32'h0000_0000, 1'b1, 1'b0); check_flags("R6 zero ignored");
    issue(32'h8000_0000, 1'b1, 1'b0); check_flags("R6 negative ignored");
  endtask

  task automatic t_timing;
    @(negedge clk);
    alu_result = 32'h8000_0000; alu_ovf = 1'b1; set_flags = 1'b1;
    #1 check_flags("R7 before edge");
    @(posedge clk); #1;
    set_flags = 1'b0;
    m_n = 1; m_z = 0; m_p = 0; m_v = 1;
    check_flags("R7 after edge");
  endtask

  task automatic sweep(input string req);
    for (int c = 0; c < 8; c++) begin
      cond_sel = c[2:0];
      #0.2;
      chk(take_branch == cond_ref(c), req, {31'd0, take_branch},
          {31'd0, cond_ref(c)});
    end
  endtask

  task automatic t_conditions;
    issue(32'h0000_0000, 1'b0, 1'b1); sweep("R8 zero pattern");
    issue(32'h0000_0042, 1'b1, 1'b1); sweep("R8 positive ovf pattern");
    issue(32'hF000_0000, 1'b0, 1'b1); sweep("R8 negative pattern");
  endtask

  task automatic t_compare_branch;
    // 5 - 9 = -4: less-than test, then unrelated work, then branch on N
    issue(32'd5 - 32'd9, 1'b0, 1'b1);
    issue(32'd0, 1'b0, 1'b0);
    issue(32'h1234_5678, 1'b0, 1'b0);
    cond_sel = 3'd1; #0.2;
    chk(take_branch == 1'b1, "R9 lt branch taken", {31'd0, take_branch}, 32'd1);
    // 9 - 5 = 4: not less-than
    issue(32'd9 - 32'd5, 1'b0, 1'b1);
    issue(32'h8000_0000, 1'b0, 1'b0);
    cond_sel = 3'd1; #0.2;
    chk(take_branch == 1'b0, "R9 ge branch not taken", {31'd0, take_branch}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_negative();
    t_zero();
    t_positive();
    t_overflow();
    t_hold();
    t_timing();
    t_conditions();
    t_compare_branch();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule